// File: doc/BRIEF.md
# Event Pulse-Length Monitor

This block watches multi-cycle events for a performance-monitoring unit. An event of this kind goes high when some condition starts and stays high while it lasts, so the monitor measures how long each pulse is rather than how many events occur. One lane is built for every event of every core. Each lane has three parts: a saturating counter of the current pulse length, a high-water mark of the longest pulse seen, and a comparison against a programmable per-event weight.

When a pulse reaches its weight, the lane's bit in its core's interrupt vector is set. The bit stays set until the unit is disabled or reset. All vector bits are OR-reduced, together with the previous interrupt state, into one unit-wide interrupt line. Events, weights and watermarks travel as flat vectors, so the parent unit can wire them straight to its own registers.

Top module: `pulse_mon`

## Requirements
- R1: The block has one lane per event per core. Lane k = core*EV_PER_CORE + event uses `events_i[k]`, `weights_i[k*LEN_W +: LEN_W]`, `watermark_o[k*LEN_W +: LEN_W]` and `irq_vec_o[k]`. Changing the parameters needs no edit to the source.
- R2: While `rst_ni` is low, all pulse counters, watermarks, `irq_vec_o` and `irq_o` are zero.
- R3: With `en_i` high, a lane's pulse counter goes up by one on every clock edge at which its event is high, and goes back to zero on an edge at which the event is low. A pulse of N cycles leaves a watermark of at least N.
- R4: A pulse counter stops at 2^LEN_W-1 and does not wrap.
- R5: A watermark changes only while `en_i` is high and only to a larger pulse length. It takes the pulse length one edge after the counter passes it. While `en_i` is low the watermark holds.
- R6: Within a core's slice of `irq_vec_o`, bit 0 belongs to event 0, and higher bits belong to higher event indices in ascending order.
- R7: A lane raises its interrupt when its pulse length is greater than or equal to its weight. A pulse one cycle shorter than the weight does not raise it. The vector bit appears one edge after the counter reaches the weight.
- R8: Vector bits are sticky. Once set, a bit stays high while `en_i` stays high, whatever the events do.
- R9: `irq_o` is high exactly when some bit of `irq_vec_o` is high. It is the registered OR of all lanes' interrupt conditions and its own previous value.
- R10: While `en_i` is low, the pulse counters are held at zero. The clock edge that samples `en_i` low clears `irq_vec_o` and `irq_o`.
- R11: A weight of 2^LEN_W-1 still raises the interrupt once the counter saturates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Unit enable |
| events_i | input | N_CORES*EV_PER_CORE | Flat event bits, one per lane |
| weights_i | input | N_CORES*EV_PER_CORE*LEN_W | Flat per-lane pulse-length limits |
| watermark_o | output | N_CORES*EV_PER_CORE*LEN_W | Flat per-lane longest pulse seen |
| irq_vec_o | output | N_CORES*EV_PER_CORE | Sticky per-lane interrupt bits, grouped by core |
| irq_o | output | 1 | Unit-wide interrupt |

## Verification
The bound checker checks the following on every cycle:
- the per-lane counter steps by one, saturates, and drops to zero;
- watermarks never decrease and hold while the unit is disabled;
- set vector bits stay set while the unit is enabled;
- `irq_o` agrees with the OR of the vector;
- disabling the unit clears the interrupt state.

Only the bench's scenarios can show the following:
- the exact cycle at which a weight is crossed, including the case where a pulse one cycle short does not trigger;
- that the weight at saturation triggers;
- the lane-to-bit mapping across cores;
- that a watermark is refused a shorter later pulse.

These scenarios are compared lane by lane against a behavioural model on every clock.

// File: rtl/pm_pkg.sv
package pm_pkg;
  // flat lane index shared by events, weights, watermarks and vector bits
  function automatic int unsigned lane_idx(int unsigned core, int unsigned ev,
                                           int unsigned per_core);
    return core * per_core + ev;
  endfunction
endpackage

// File: rtl/pm_pulse_cnt.sv
module pm_pulse_cnt #(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             ev_i,
  output logic [LEN_W-1:0] len_o
);
  localparam logic [LEN_W-1:0] LenMax = {LEN_W{1'b1}};

  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 len_q <= '0;
    else if (!en_i || !ev_i)     len_q <= '0;
    else if (len_q != LenMax)    len_q <= len_q + 1'b1;
  end

  assign len_o = len_q;
endmodule

// File: rtl/pm_watermark.sv
module pm_watermark #(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [LEN_W-1:0] wm_o
);
  logic [LEN_W-1:0] wm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     wm_q <= '0;
    else if (en_i && (len_i > wm_q)) wm_q <= len_i;
  end

  assign wm_o = wm_q;
endmodule

// File: rtl/pm_irq_collect.sv
module pm_irq_collect #(
  parameter int N_EV = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [N_EV-1:0] hit_i,
  output logic [N_EV-1:0] vec_o,
  output logic            irq_o
);
  logic [N_EV-1:0] vec_q;
  logic            irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q <= '0;
      irq_q <= 1'b0;
    end else if (!en_i) begin
      vec_q <= '0;
      irq_q <= 1'b0;
    end else begin
      vec_q <= vec_q | hit_i;
      irq_q <= irq_q | (|hit_i);
    end
  end

  assign vec_o = vec_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/pulse_mon.sv
module pulse_mon #(
  parameter int N_CORES     = 2,
  parameter int EV_PER_CORE = 4,
  parameter int LEN_W       = 8,
  localparam int N_EV       = N_CORES * EV_PER_CORE
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic [N_EV-1:0]       events_i,
  input  logic [N_EV*LEN_W-1:0] weights_i,
  output logic [N_EV*LEN_W-1:0] watermark_o,
  output logic [N_EV-1:0]       irq_vec_o,
  output logic                  irq_o
);
  import pm_pkg::*;

  logic [N_EV*LEN_W-1:0] len_q;
  logic [N_EV-1:0]       hit;

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    for (genvar e = 0; e < EV_PER_CORE; e++) begin : g_ev
      localparam int unsigned K = lane_idx(c, e, EV_PER_CORE);

      pm_pulse_cnt #(.LEN_W(LEN_W)) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en_i),
        .ev_i   (events_i[K]),
        .len_o  (len_q[K*LEN_W +: LEN_W])
      );

      pm_watermark #(.LEN_W(LEN_W)) u_wm (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en_i),
        .len_i  (len_q[K*LEN_W +: LEN_W]),
        .wm_o   (watermark_o[K*LEN_W +: LEN_W])
      );

      // greater-or-equal so a weight at saturation still fires
      assign hit[K] = len_q[K*LEN_W +: LEN_W] >= weights_i[K*LEN_W +: LEN_W];
    end
  end

  pm_irq_collect #(.N_EV(N_EV)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .hit_i  (hit),
    .vec_o  (irq_vec_o),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/pulse_mon_chk.sv
module pulse_mon_chk #(
  parameter int N_CORES     = 2,
  parameter int EV_PER_CORE = 4,
  parameter int LEN_W       = 8,
  localparam int N_EV       = N_CORES * EV_PER_CORE
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  en_i,
  input logic [N_EV-1:0]       events_i,
  input logic [N_EV*LEN_W-1:0] watermark_o,
  input logic [N_EV-1:0]       irq_vec_o,
  input logic                  irq_o,
  input logic [N_EV*LEN_W-1:0] len_q
);
  localparam logic [LEN_W-1:0] LenMax = {LEN_W{1'b1}};

  for (genvar k = 0; k < N_EV; k++) begin : g_lane
    AST_LEN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && events_i[k] && len_q[k*LEN_W +: LEN_W] != LenMax)
      |=> len_q[k*LEN_W +: LEN_W] == $past(len_q[k*LEN_W +: LEN_W]) + 1'b1); // R3
    AST_LEN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i || !events_i[k]) |=> len_q[k*LEN_W +: LEN_W] == '0); // R10
    AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && events_i[k] && len_q[k*LEN_W +: LEN_W] == LenMax)
      |=> len_q[k*LEN_W +: LEN_W] == LenMax); // R4
    AST_WM_MONOTONIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i |=> watermark_o[k*LEN_W +: LEN_W] >= $past(watermark_o[k*LEN_W +: LEN_W])); // R5
    AST_WM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> $stable(watermark_o[k*LEN_W +: LEN_W])); // R5
    AST_VEC_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && irq_vec_o[k]) |=> irq_vec_o[k]); // R8
  end

  AST_IRQ_OR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (|irq_vec_o)); // R9
  AST_DIS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!irq_o && irq_vec_o == '0)); // R10
endmodule

bind pulse_mon pulse_mon_chk #(
  .N_CORES(N_CORES), .EV_PER_CORE(EV_PER_CORE), .LEN_W(LEN_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .events_i    (events_i),
  .watermark_o (watermark_o),
  .irq_vec_o   (irq_vec_o),
  .irq_o       (irq_o),
  .len_q       (len_q)
);

// File: tb/pulse_mon_tb.sv
module pulse_mon_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_CORES = 2, EPC = 4, LEN_W = 8;
  localparam int N_EV = N_CORES * EPC;
  localparam int MAXV = (1 << LEN_W) - 1;

  logic clk = 0, rst_n = 0, en = 0;
  logic [N_EV-1:0] ev = '0;
  logic [LEN_W-1:0] w [N_EV];
  logic [N_EV*LEN_W-1:0] weights, wm_o;
  logic [N_EV-1:0] vec_o;
  logic irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb
    for (int k = 0; k < N_EV; k++) weights[k*LEN_W +: LEN_W] = w[k];

  pulse_mon #(.N_CORES(N_CORES), .EV_PER_CORE(EPC), .LEN_W(LEN_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .events_i(ev), .weights_i(weights),
    .watermark_o(wm_o), .irq_vec_o(vec_o), .irq_o(irq));

  int n_chk = 0, n_fail = 0, cyc = 0;

  // behavioural reference: per-lane integers
  int m_len [N_EV], m_wm [N_EV], m_vec [N_EV];
  int m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N_EV; k++) begin m_len[k] = 0; m_wm[k] = 0; m_vec[k] = 0; end
      m_irq = 0;
    end else begin
      int any; any = 0;
      for (int k = 0; k < N_EV; k++) begin
        int hitk; hitk = (m_len[k] >= int'(w[k])) ? 1 : 0;
        if (en) begin
          if (hitk != 0) begin m_vec[k] = 1; any = 1; end
          if (m_len[k] > m_wm[k]) m_wm[k] = m_len[k];
          m_len[k] = ev[k] ? ((m_len[k] < MAXV) ? m_len[k] + 1 : MAXV) : 0;
        end else begin
          m_vec[k] = 0;
          m_len[k] = 0;
        end
      end
      m_irq = en ? ((m_irq != 0 || any != 0) ? 1 : 0) : 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, lane by lane (R1)
  always @(negedge clk) if (rst_n) begin
    for (int k = 0; k < N_EV; k++) begin
      chk(int'(wm_o[k*LEN_W +: LEN_W]) == m_wm[k], "R5 watermark lane", int'(wm_o[k*LEN_W +: LEN_W]), m_wm[k]);
      chk(int'(vec_o[k]) == m_vec[k], "R8 vector bit lane", int'(vec_o[k]), m_vec[k]);
    end
    chk(int'(irq) == m_irq, "R9 irq_o", int'(irq), m_irq);
  end

  task automatic cyc_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int k, input int n);
    ev[k] = 1'b1;
    cyc_n(n);
    ev[k] = 1'b0;
    cyc_n(2);
  endtask

  function automatic int wm(input int k);
    return int'(wm_o[k*LEN_W +: LEN_W]);
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog expired act=%0d exp=%0d", cyc, 100000);
      finish_run();
    end
  end

  initial begin
    for (int k = 0; k < N_EV; k++) w[k] = LEN_W'(MAXV);
    cyc_n(3);
    // R2: reset state
    chk(wm_o == '0, "R2 watermarks in reset", int'(|wm_o), 0);
    chk(vec_o == '0 && !irq, "R2 irq in reset", int'(vec_o), 0);
    rst_n = 1'b1;
    cyc_n(1);
    en = 1'b1;
    // R3: pulse length measured
    pulse(0, 6);
    chk(wm(0) == 6, "R3 lane0 six-cycle pulse", wm(0), 6);
    pulse(3, 3);
    chk(wm(3) == 3, "R3 lane3 three-cycle pulse", wm(3), 3);
    // R5: shorter pulse does not lower the watermark
    pulse(3, 2);
    chk(wm(3) == 3, "R5 shorter pulse keeps watermark", wm(3), 3);
    // R5: disabled holds watermark
    en = 1'b0;
    ev = '1; cyc_n(20); ev = '0; cyc_n(2);
    chk(wm(0) == 6 && wm(3) == 3 && wm(1) == 0, "R5 hold while disabled", wm(1), 0);
    // R10: counters held at zero while disabled, restart on enable
    ev[6] = 1'b1; cyc_n(10);
    en = 1'b1; cyc_n(3); ev[6] = 1'b0; cyc_n(2);
    chk(wm(6) == 3, "R10 counter held at zero while disabled", wm(6), 3);
    // R7: threshold is greater-or-equal
    w[5] = LEN_W'(5);
    pulse(5, 4);
    chk(vec_o == '0 && !irq, "R7 pulse below weight", int'(vec_o), 0);
    pulse(5, 5);
    // R6: core 1 event 1 -> flat bit 5
    chk(vec_o == N_EV'(1 << 5), "R6 bit mapping core1 ev1", int'(vec_o), 1 << 5);
    chk(irq == 1'b1, "R9 irq raised", int'(irq), 1);
    // R8: sticky while enabled
    cyc_n(10);
    chk(vec_o[5] == 1'b1 && irq, "R8 sticky", int'(vec_o[5]), 1);
    // R10: disable clears on next edge
    en = 1'b0; cyc_n(1);
    chk(vec_o == '0 && !irq, "R10 disable clears irq", int'(irq), 0);
    en = 1'b1; w[5] = LEN_W'(MAXV); cyc_n(1);
    // R4 and R11: saturation and weight at max
    w[2] = LEN_W'(MAXV);
    pulse(2, 300);
    chk(wm(2) == MAXV, "R4 saturated watermark", wm(2), MAXV);
    chk(vec_o == N_EV'(1 << 2) && irq, "R11 weight at max fires", int'(vec_o), 1 << 2);
    // R1: random traffic across all lanes, compared each cycle
    for (int r = 0; r < 6; r++) begin
      en = 1'b0; cyc_n(1); en = 1'b1;
      for (int k = 0; k < N_EV; k++) w[k] = LEN_W'(2 + ($urandom % 12));
      for (int i = 0; i < 400; i++) begin
        if ($urandom % 4 == 0) ev = N_EV'($urandom);
        if ($urandom % 97 == 0) en = ~en;
        cyc_n(1);
      end
    end
    ev = '0; cyc_n(4);
    finish_run();
  end
endmodule